// File: doc/BRIEF.md
# Length-Prefixed Packet Capture Controller

This block sits behind a sync-word detector in a low-rate serial receiver. When the detector's match flag rises, the block takes the following recovered bits from a strobed bit stream. The first four bits give the message length. The bits after them are packed into bytes and written into a small buffer. When the last byte is stored, the block pulses the detector's clear input, sets a request flag and, if interrupts are enabled, pulls an active-low interrupt pin low.

A free-running 11-bit counter counts rising edges of a comparator output and serves as a coarse energy figure. Its upper eight bits are readable. A host-side read port exposes one address space: the length value at address 0, the data bytes after it, and the energy byte just past the last data byte. A read-clear strobe, which the host logic raises when a data read is finished, drops the request and zeroes the energy counter.

Top module: `pkt_capture`

## Requirements
- R1: After synchronous reset, `len_out`, `energy`, `req_flag` and `det_clr` are 0, `irq_n` is 1, and reads of addresses 0, 1 and 2 return 0.
- R2: After a rising edge of `sync_match` with the request flag clear, the next four strobed bits (first bit = bit 3) form the byte count minus one. 0000 means 1 byte and 1111 means 16 bytes. The value appears on `len_out` and at read address 0 as {4'b0000, count-1}.
- R3: Data bits are packed most significant bit first. Byte k of the message (k from 0) is read at address k+1. `rd_data` shows the word for the `rd_addr` of the previous cycle.
- R4: On the clock edge that takes the last bit of the last byte, `req_flag` becomes 1 and `det_clr` goes high for exactly one cycle.
- R5: `irq_n` is registered and is 0 exactly when the request flag and `irq_en` were both 1 at the preceding edge. With `irq_en` at 0, a completed message leaves `irq_n` at 1.
- R6: Each rising edge of `cmp_pulse` adds one to an 11-bit counter. `energy` is counter bits 10..3, so it advances once per eight edges. The same byte is read at address count+1, directly after the last data byte.
- R7: `rd_clr` high at an edge clears the request flag, releases `irq_n` and zeroes the energy counter. If it coincides with a message completion, the request is still set. If it coincides with a comparator edge, the counter ends at 0.
- R8: While the request flag is set, a new `sync_match` rise and its bits are ignored: the length, the buffer and the flags are unchanged, and no `det_clr` pulse is made.
- R9: Addresses above the energy address read 0.
- R10: A 16-byte message (prefix 1111) fills addresses 01h to 10h, and the energy byte is at 11h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered data bit, valid with bit_stb |
| bit_stb | input | 1 | One-cycle strobe per received bit |
| sync_match | input | 1 | Sync-word detector match flag |
| cmp_pulse | input | 1 | Comparator output; rising edges are counted |
| irq_en | input | 1 | Interrupt enable |
| rd_clr | input | 1 | Read-clear strobe from host logic |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, one cycle after rd_addr |
| len_out | output | 4 | Stored byte count minus one |
| energy | output | 8 | Upper 8 bits of the energy counter |
| irq_n | output | 1 | Active-low interrupt |
| req_flag | output | 1 | Request flag, set at message completion |
| det_clr | output | 1 | One-cycle clear pulse to the sync detector |

## Verification
The request flag has a setter and a clearer, and both can act on the same edge. A message completion can land in the same cycle as a host read-clear. The bench forces this by raising `rd_clr` and a comparator edge together with the strobe of the final data bit. It then expects the request still set and the energy counter at zero, which shows that set wins on the flag and clear wins on the counter. A second overlap is a new sync rise while a request is still pending; the bench judges it by reading back the length and the first byte unchanged.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEN, ST_DATA} cap_state_e;
  typedef enum logic [1:0] {RS_ZERO, RS_MEM, RS_AUX} rd_sel_e;
endpackage

// File: rtl/pcap_deser.sv
module pcap_deser #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   stb,
  input  logic                   din,
  output logic [DW-2:0]          prev_bits,
  output logic [$clog2(DW)-1:0]  nbits
);
  localparam int NBW = $clog2(DW);

  logic [DW-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      nbits <= '0;
    end else begin
      if (stb) sh <= {sh[DW-3:0], din};
      if (clr)      nbits <= '0;
      else if (stb) nbits <= nbits + NBW'(1);
    end
  end

  assign prev_bits = sh;
endmodule

// File: rtl/pcap_energy.sv
module pcap_energy #(
  parameter int CW = 11,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pulse,
  input  logic          clr,
  output logic [OW-1:0] cnt_hi
);
  logic [CW-1:0] cnt;
  logic          pulse_q;
  logic          rise;

  assign rise = pulse & ~pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse;
      if (clr)       cnt <= '0;
      else if (rise) cnt <= cnt + CW'(1);
    end
  end

  assign cnt_hi = cnt[CW-1 -: OW];

  // R6
  energy_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !rise) |=> $stable(cnt));
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_in,
  input  logic          bit_stb,
  input  logic          sync_match,
  input  logic          rd_clr,
  input  logic          irq_en,
  output logic          wr_en,
  output logic [LW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [LW-1:0] len_q,
  output logic          req_flag,
  output logic          det_clr,
  output logic          irq_n
);
  localparam int NBW = $clog2(DW);
  localparam logic [NBW-1:0] LEN_LAST  = NBW'(LW - 1);
  localparam logic [NBW-1:0] BYTE_LAST = NBW'(DW - 1);

  cap_state_e    state;
  logic          match_q;
  logic [LW-1:0] byte_idx;
  logic [DW-2:0] prev_bits;
  logic [NBW-1:0] nbits;
  logic          match_rise, last_len, last_bit, msg_done, sh_clr, req_nxt;

  assign match_rise = sync_match & ~match_q;
  assign last_len   = (state == ST_LEN)  && bit_stb && (nbits == LEN_LAST);
  assign last_bit   = (state == ST_DATA) && bit_stb && (nbits == BYTE_LAST);
  assign msg_done   = last_bit && (byte_idx == len_q);
  assign sh_clr     = (state == ST_IDLE) || last_len || last_bit;
  assign req_nxt    = msg_done ? 1'b1 : (rd_clr ? 1'b0 : req_flag);

  pcap_deser #(.DW(DW)) u_deser (
    .clk(clk), .rst(rst), .clr(sh_clr), .stb(bit_stb), .din(bit_in),
    .prev_bits(prev_bits), .nbits(nbits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      match_q  <= 1'b0;
      byte_idx <= '0;
      len_q    <= '0;
      req_flag <= 1'b0;
      det_clr  <= 1'b0;
      irq_n    <= 1'b1;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      match_q  <= sync_match;
      req_flag <= req_nxt;
      irq_n    <= ~(req_nxt & irq_en);
      det_clr  <= msg_done;
      wr_en    <= last_bit;
      wr_idx   <= byte_idx;
      wr_data  <= {prev_bits, bit_in};
      case (state)
        ST_IDLE: if (match_rise && !req_flag) state <= ST_LEN;
        ST_LEN: if (last_len) begin
          len_q    <= {prev_bits[LW-2:0], bit_in};
          byte_idx <= '0;
          state    <= ST_DATA;
        end
        ST_DATA: if (last_bit) begin
          if (msg_done) state <= ST_IDLE;
          else          byte_idx <= byte_idx + LW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  det_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    det_clr |=> !det_clr);
  // R4
  det_req_chk: assert property (@(posedge clk) disable iff (rst)
    det_clr |-> req_flag);
  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> req_flag);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_flag |=> (state == ST_IDLE));
  // R3
  wr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= len_q));
endmodule

// File: rtl/pcap_buf.sv
module pcap_buf
  import pcap_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 4,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] len_q,
  input  logic [EW-1:0] energy,
  input  logic [LW:0]   rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << LW;
  localparam int AW    = LW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rd, aux, aux_q;
  logic [LW-1:0] idx;
  logic [AW-1:0] last_data, energy_addr;
  rd_sel_e       sel, sel_q;

  assign idx         = rd_addr[LW-1:0] - LW'(1);
  assign last_data   = AW'(len_q) + AW'(1);
  assign energy_addr = AW'(len_q) + AW'(2);

  always_comb begin
    sel = RS_ZERO;
    aux = '0;
    if (rd_addr == '0) begin
      sel = RS_AUX;
      aux = DW'(len_q);
    end else if (rd_addr <= last_data) begin
      sel = RS_MEM;
    end else if (rd_addr == energy_addr) begin
      sel = RS_AUX;
      aux = DW'(energy);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem_rd <= '0;
      aux_q  <= '0;
      sel_q  <= RS_ZERO;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      mem_rd <= mem[idx];
      aux_q  <= aux;
      sel_q  <= sel;
    end
  end

  always_comb begin
    case (sel_q)
      RS_MEM:  rd_data = mem_rd;
      RS_AUX:  rd_data = aux_q;
      default: rd_data = '0;
    endcase
  end

  // R9
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == RS_ZERO) |-> (rd_data == '0));
endmodule

// File: rtl/pkt_capture.sv
module pkt_capture #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int ECNT_W = 11,
  parameter int EOUT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              sync_match,
  input  logic              cmp_pulse,
  input  logic              irq_en,
  input  logic              rd_clr,
  input  logic [LEN_W:0]    rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  len_out,
  output logic [EOUT_W-1:0] energy,
  output logic              irq_n,
  output logic              req_flag,
  output logic              det_clr
);
  logic              wr_en;
  logic [LEN_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  pcap_ctrl #(.DW(DATA_W), .LW(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
    .sync_match(sync_match), .rd_clr(rd_clr), .irq_en(irq_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .len_q(len_out),
    .req_flag(req_flag), .det_clr(det_clr), .irq_n(irq_n)
  );

  pcap_energy #(.CW(ECNT_W), .OW(EOUT_W)) u_energy (
    .clk(clk), .rst(rst), .pulse(cmp_pulse), .clr(rd_clr), .cnt_hi(energy)
  );

  pcap_buf #(.DW(DATA_W), .LW(LEN_W), .EW(EOUT_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .len_q(len_out), .energy(energy), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_pkt_capture.sv
module sim_pkt_capture;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, bit_in = 1'b0, bit_stb = 1'b0, sync_match = 1'b0;
  logic cmp_pulse = 1'b0, irq_en = 1'b0, rd_clr = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data, energy;
  logic [3:0] len_out;
  logic irq_n, req_flag, det_clr;

  pkt_capture u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
    .sync_match(sync_match), .cmp_pulse(cmp_pulse), .irq_en(irq_en),
    .rd_clr(rd_clr), .rd_addr(rd_addr), .rd_data(rd_data), .len_out(len_out),
    .energy(energy), .irq_n(irq_n), .req_flag(req_flag), .det_clr(det_clr)
  );

  int errors = 0, checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {logic [4:0] addr; logic [7:0] exp; string tag; longint due;} rd_item_t;
  rd_item_t sbq[$];
  logic [7:0] msg [16];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data one cycle after the address
  always @(negedge clk) begin : mon
    rd_item_t it;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      chk(it.tag, {24'd0, rd_data}, {24'd0, it.exp});
    end
  end

  task automatic read_at(logic [4:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    rd_addr = a;
    sbq.push_back('{a, e, tag, cyc + 1});
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic put_bit(logic b, logic with_clr);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1; rd_clr = with_clr; cmp_pulse = with_clr;
    @(negedge clk);
    bit_stb = 1'b0; rd_clr = 1'b0; cmp_pulse = 1'b0;
  endtask

  task automatic send_msg(logic [3:0] n, logic clr_last);
    @(negedge clk) sync_match = 1'b1;
    @(negedge clk);
    for (int i = 3; i >= 0; i--) put_bit(n[i], 1'b0);
    for (int b = 0; b <= int'(n); b++)
      for (int k = 7; k >= 0; k--)
        put_bit(msg[b][k], clr_last && b == int'(n) && k == 0);
  endtask

  task automatic pulse_cmp(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cmp_pulse = 1'b1;
      @(negedge clk) cmp_pulse = 1'b0;
    end
  endtask

  task automatic host_clear();
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 len_out", len_out, 0);
    chk("R1 energy", energy, 0);
    chk("R1 req_flag", req_flag, 0);
    chk("R1 det_clr", det_clr, 0);
    chk("R1 irq_n", irq_n, 1);
    read_at(0, 8'h00, "R1 addr0");
    read_at(1, 8'h00, "R1 addr1");
    read_at(2, 8'h00, "R1 addr2");
    drain();

    // three-byte message with interrupts disabled, 20 comparator edges
    pulse_cmp(20);
    chk("R6 energy 20 edges", energy, 2);
    msg[0] = 8'hA5; msg[1] = 8'h3C; msg[2] = 8'hF0;
    send_msg(4'd2, 1'b0);
    chk("R4 det_clr pulse", det_clr, 1);
    chk("R4 req set", req_flag, 1);
    chk("R5 irq masked", irq_n, 1);
    @(negedge clk);
    sync_match = 1'b0;
    chk("R4 det_clr one cycle", det_clr, 0);
    chk("R2 len_out", len_out, 2);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R5 irq enabled", irq_n, 0);
    read_at(0, 8'h02, "R2 addr0");
    read_at(1, 8'hA5, "R3 byte0");
    read_at(2, 8'h3C, "R3 byte1");
    read_at(3, 8'hF0, "R3 byte2");
    read_at(4, 8'h02, "R6 energy addr");
    read_at(5, 8'h00, "R9 past energy");
    read_at(31, 8'h00, "R9 top addr");
    drain();

    // new message while request pending is ignored
    msg[0] = 8'h11;
    send_msg(4'd0, 1'b0);
    chk("R8 no det_clr", det_clr, 0);
    @(negedge clk);
    sync_match = 1'b0;
    chk("R8 len kept", len_out, 2);
    chk("R8 req kept", req_flag, 1);
    read_at(0, 8'h02, "R8 addr0 kept");
    read_at(1, 8'hA5, "R8 byte0 kept");
    drain();

    // host read-clear
    host_clear();
    chk("R7 req cleared", req_flag, 0);
    chk("R7 irq released", irq_n, 1);
    chk("R7 energy cleared", energy, 0);

    // full sixteen-byte message
    pulse_cmp(9);
    for (int i = 0; i < 16; i++) msg[i] = 8'(i * 17 + 3);
    send_msg(4'hF, 1'b0);
    chk("R10 req set", req_flag, 1);
    chk("R5 irq low", irq_n, 0);
    @(negedge clk) sync_match = 1'b0;
    read_at(0, 8'h0F, "R10 addr0");
    for (int i = 1; i <= 16; i++) read_at(5'(i), msg[i-1], "R10 byte");
    read_at(5'h11, 8'h01, "R10 energy at 11h");
    drain();

    // completion in the same cycle as read-clear and a comparator edge
    host_clear();
    pulse_cmp(16);
    chk("R6 energy 16 edges", energy, 2);
    msg[0] = 8'h81;
    send_msg(4'd0, 1'b1);
    chk("R7 set wins", req_flag, 1);
    chk("R7 clear wins energy", energy, 0);
    chk("R4 det_clr coincident", det_clr, 1);
    @(negedge clk) sync_match = 1'b0;
    read_at(0, 8'h00, "R2 len zero");
    read_at(1, 8'h81, "R3 single byte");
    read_at(2, 8'h00, "R6 energy addr 2");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule